// File: doc/BRIEF.md
# Tap-Selectable Sampled Delay Line

This block delays a one-bit sampled stream by a programmable number of clock cycles. The stream passes through a fixed entry pipeline and then a serial chain of `2**SEL_W` register stages. An `SEL_W`-bit select word chooses which chain stage drives the output. The total delay is therefore an inherent offset of `INHERENT` cycles plus the select value. The output is a non-inverted, time-shifted copy of the input.

A select word offered on the load strobe does not take effect at once. It is held as pending until the input has been quiet for the full maximum delay of the line, `MAX_DLY = INHERENT + 2**SEL_W - 1` cycles. By then every stage holds the same level, so switching the tap cannot create a false edge. When the new tap is applied, a valid flag drops for `SETTLE` cycles. After reset the flag stays low until the line has filled.

Top module: `tap_delay_line`

## Requirements
- R1: While `rst_n` is low, `dout` and `dout_valid` are 0 and every stage is cleared. After reset the active select is 0.
- R2: With active select 0, `dout` after clock edge n equals `din` as sampled at edge n-(INHERENT-1). This is a delay of `INHERENT` cycles with no inversion. Samples from before reset count as 0.
- R3: With active select s, `dout` after edge n equals `din` sampled at edge n-(INHERENT-1)-s. Each select step adds exactly one cycle, up to s = 2**SEL_W-1.
- R4: A pulse on `sel_load` captures `sel_in` as a pending select. The pending select becomes active at the first edge at which the idle count equals MAX_DLY. The idle count is the number of consecutive edges at which `din` matched its previous sample; reset counts as a previous sample of 0.
- R5: Any change of `din` clears the idle count. While `din` keeps changing, a pending select never becomes active.
- R6: A later `sel_load` overwrites an earlier pending value that has not been applied yet. Only the last one takes effect.
- R7: If `sel_load` is high at the same edge at which a pending value is applied, the older value becomes active. The newly loaded value stays pending.
- R8: At the edge that applies a pending select, `dout_valid` goes low. It rises again exactly SETTLE edges later, unless another apply restarts the window.
- R9: After reset is released, `dout_valid` rises at the MAX_DLY-th edge.
- R10: Applying a new select never changes `dout` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one cycle is one delay step |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Sampled input stream |
| sel_in | input | SEL_W | Requested tap select |
| sel_load | input | 1 | Strobe capturing `sel_in` as pending |
| dout | output | 1 | Delayed copy of `din` |
| dout_valid | output | 1 | High when the delay is settled |

## Verification
The interesting collision is a new `sel_load` landing on the very edge at which the previous pending select is applied. The bench holds `din` idle after one load and watches its reference model until the idle count is full with a value pending. It then strobes a second select into exactly that cycle. The scoreboard expects the first value to become active at that edge, with a settle window. It expects the second value to follow one edge later, restarting the window, while `dout` stays flat across both tap switches.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

   // Larger of two non-negative sizes, used when one counter must span both.
   function automatic int unsigned tdl_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // Bits needed to hold values 0..v inclusive.
   function automatic int unsigned tdl_cnt_w(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/tdl_shift.sv
module tdl_shift #(
   parameter int unsigned INHERENT = 2,
   parameter int unsigned DEPTH    = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   output logic [DEPTH-1:0] taps
);
   localparam int unsigned PRE = INHERENT - 1;

   logic chain_in;

   generate
      if (PRE == 0) begin : g_no_pre
         assign chain_in = din;
      end else if (PRE == 1) begin : g_one_pre
         logic pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pre_q <= 1'b0;
            else        pre_q <= din;
         end
         assign chain_in = pre_q;
      end else begin : g_multi_pre
         logic [PRE-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pre_q <= '0;
            else        pre_q <= {pre_q[PRE-2:0], din};
         end
         assign chain_in = pre_q[PRE-1];
      end
   endgenerate

   // Stage k holds the chain input seen k edges ago.
   always_ff @(posedge clk) begin
      if (!rst_n) taps <= '0;
      else        taps <= {taps[DEPTH-2:0], chain_in};
   end

endmodule

// File: rtl/tdl_tap_mux.sv
module tdl_tap_mux #(
   parameter int unsigned SEL_W = 8,
   parameter int unsigned DEPTH = 256
) (
   input  logic [DEPTH-1:0] taps,
   input  logic [SEL_W-1:0] sel,
   output logic             dout
);
   always_comb dout = taps[sel];
endmodule

// File: rtl/tdl_update_guard.sv
module tdl_update_guard #(
   parameter int unsigned SEL_W   = 8,
   parameter int unsigned MAX_DLY = 257,
   parameter int unsigned SETTLE  = 4,
   parameter int unsigned CW      = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             sel_load,
   output logic [SEL_W-1:0] sel_act,
   output logic             valid
);
   logic             last_din;
   logic [CW-1:0]    idle_cnt;
   logic             pend_vld;
   logic [SEL_W-1:0] pend_sel;
   logic [CW-1:0]    wait_cnt;
   logic             apply;

   assign apply = pend_vld && (idle_cnt == CW'(MAX_DLY));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_din <= 1'b0;
         idle_cnt <= '0;
      end else begin
         last_din <= din;
         if (din != last_din)              idle_cnt <= '0;
         else if (idle_cnt != CW'(MAX_DLY)) idle_cnt <= idle_cnt + CW'(1);
      end
   end

   // A load in the apply cycle replaces the pending slot; the old value goes active.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_vld <= 1'b0;
         pend_sel <= '0;
         sel_act  <= '0;
      end else begin
         if (sel_load) begin
            pend_vld <= 1'b1;
            pend_sel <= sel_in;
         end else if (apply) begin
            pend_vld <= 1'b0;
         end
         if (apply) sel_act <= pend_sel;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_cnt <= CW'(MAX_DLY);
         valid    <= 1'b0;
      end else if (apply) begin
         wait_cnt <= CW'(SETTLE);
         valid    <= 1'b0;
      end else if (wait_cnt != '0) begin
         wait_cnt <= wait_cnt - CW'(1);
         if (wait_cnt == CW'(1)) valid <= 1'b1;
      end
   end

   // R4
   sel_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_act != $past(sel_act)) |-> ($past(idle_cnt) == CW'(MAX_DLY)));

   // R6
   load_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_load |=> (pend_vld && (pend_sel == $past(sel_in))));

   // R8
   apply_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_act != $past(sel_act)) |-> !valid);

   // R8
   valid_rise_timed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> ($past(wait_cnt) == CW'(1)));

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
   parameter int unsigned SEL_W    = 8,
   parameter int unsigned INHERENT = 2,
   parameter int unsigned SETTLE   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             sel_load,
   output logic             dout,
   output logic             dout_valid
);
   import tdl_pkg::*;

   localparam int unsigned DEPTH   = 1 << SEL_W;
   localparam int unsigned MAX_DLY = INHERENT + DEPTH - 1;
   localparam int unsigned CW      = tdl_cnt_w(tdl_max(MAX_DLY, SETTLE));

   generate
      if (SEL_W < 1 || SEL_W > 12) begin : g_bad_sel_w
         $error("tap_delay_line: SEL_W must lie in 1..12");
      end
      if (INHERENT < 1) begin : g_bad_inherent
         $error("tap_delay_line: INHERENT must be at least 1");
      end
      if (SETTLE < 1) begin : g_bad_settle
         $error("tap_delay_line: SETTLE must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] taps;
   logic [SEL_W-1:0] sel_act;

   tdl_shift #(.INHERENT(INHERENT), .DEPTH(DEPTH)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (din),
      .taps  (taps)
   );

   tdl_update_guard #(.SEL_W(SEL_W), .MAX_DLY(MAX_DLY), .SETTLE(SETTLE), .CW(CW)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (din),
      .sel_in   (sel_in),
      .sel_load (sel_load),
      .sel_act  (sel_act),
      .valid    (dout_valid)
   );

   tdl_tap_mux #(.SEL_W(SEL_W), .DEPTH(DEPTH)) u_mux (
      .taps (taps),
      .sel  (sel_act),
      .dout (dout)
   );

   // R10
   no_glitch_on_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_act != $past(sel_act)) |-> (dout == $past(dout)));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!dout && !dout_valid));

endmodule

// File: tb/test_tap_delay_line.sv
module test_tap_delay_line;
   localparam int SEL_W    = 8;
   localparam int INHERENT = 2;
   localparam int SETTLE   = 4;
   localparam int DEPTH    = 1 << SEL_W;
   localparam int MAX_DLY  = INHERENT + DEPTH - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             din = 1'b0;
   logic [SEL_W-1:0] sel_in = '0;
   logic             sel_load = 1'b0;
   logic             dout;
   logic             dout_valid;

   always #5 clk = ~clk;

   tap_delay_line #(.SEL_W(SEL_W), .INHERENT(INHERENT), .SETTLE(SETTLE)) i_tap_delay_line (
      .clk(clk), .rst_n(rst_n), .din(din), .sel_in(sel_in),
      .sel_load(sel_load), .dout(dout), .dout_valid(dout_valid)
   );

   int    errors = 0;
   int    checks = 0;
   string dreq = "R1";
   string vreq = "R1";

   // Reference model, stepped from the requirements at each active edge.
   bit    hist [int];
   int    n = 0;
   int    m_idle = 0;
   bit    m_last = 0;
   bit    m_pend = 0;
   int    m_psel = 0;
   int    m_sel = 0;
   int    m_wait = MAX_DLY;
   bit    m_valid = 0;

   typedef struct {
      bit    d;
      bit    v;
      string dr;
      string vr;
      int    edge_no;
   } exp_t;
   exp_t q[$];
   exp_t e;

   function automatic bit past_din(input int idx);
      if (idx < 1 || !hist.exists(idx)) return 1'b0;
      return hist[idx];
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit   ap;
         exp_t x;
         ap = m_pend && (m_idle == MAX_DLY);
         n++;
         hist[n] = din;
         if (din != m_last) m_idle = 0;
         else if (m_idle != MAX_DLY) m_idle++;
         m_last = din;
         if (ap) m_sel = m_psel;
         if (sel_load) begin
            m_pend = 1;
            m_psel = int'(sel_in);
         end else if (ap) begin
            m_pend = 0;
         end
         if (ap) begin
            m_wait = SETTLE;
            m_valid = 0;
         end else if (m_wait != 0) begin
            if (m_wait == 1) m_valid = 1;
            m_wait--;
         end
         x.d = past_din(n - (INHERENT - 1) - m_sel);
         x.v = m_valid;
         x.dr = dreq;
         x.vr = vreq;
         x.edge_no = n;
         q.push_back(x);
      end
   end

   // Monitor: compares design outputs shortly after each edge.
   always @(posedge clk) begin
      if (rst_n) begin
         #2;
         e = q.pop_front();
         checks++;
         if (dout !== e.d) begin
            errors++;
            $display("FAIL %s edge %0d: dout=%0b expected %0b", e.dr, e.edge_no, dout, e.d);
         end
         checks++;
         if (dout_valid !== e.v) begin
            errors++;
            $display("FAIL %s edge %0d: dout_valid=%0b expected %0b", e.vr, e.edge_no, dout_valid, e.v);
         end
      end
   end

   task automatic direct_check(input string req, input bit act, input bit exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp_v);
      end
   endtask

   task automatic toggle_run(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if ((i % ((i / 16) % 7 + 1)) == 0) din = ~din;
      end
   endtask

   task automatic hold(input int cycles);
      repeat (cycles) @(negedge clk);
   endtask

   task automatic load_sel(input int value);
      @(negedge clk);
      sel_in = SEL_W'(value);
      sel_load = 1'b1;
      @(negedge clk);
      sel_load = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      direct_check("R1", dout, 1'b0);
      direct_check("R1", dout_valid, 1'b0);
      rst_n = 1'b1;

      // R2 delay at select 0, R9 valid after fill
      dreq = "R2"; vreq = "R9";
      toggle_run(320);

      // R5: pending select is held off by a busy input
      dreq = "R5"; vreq = "R8";
      load_sel(5);
      toggle_run(300);
      direct_check("R5", m_pend, 1'b1);

      // R10/R4: idle long enough, tap switches without an edge
      dreq = "R10";
      hold(MAX_DLY + 10);
      dreq = "R3";
      toggle_run(400);

      // R6: last of two loads wins
      dreq = "R6";
      load_sel(10);
      load_sel(200);
      hold(MAX_DLY + 10);
      toggle_run(500);

      // R7: load lands on the apply edge
      dreq = "R7"; vreq = "R7";
      load_sel(77);
      while (!(m_pend && m_idle == MAX_DLY)) @(negedge clk);
      sel_in = SEL_W'(33);
      sel_load = 1'b1;
      @(negedge clk);
      sel_load = 1'b0;
      hold(20);
      toggle_run(300);

      // R3: maximum tap, then back to zero
      dreq = "R3"; vreq = "R8";
      load_sel(DEPTH - 1);
      hold(MAX_DLY + 10);
      toggle_run(600);
      dreq = "R4";
      load_sel(0);
      hold(MAX_DLY + 10);
      toggle_run(60);

      hold(3);
      finish_run();
   end

endmodule